// File: doc/BRIEF.md
# Multi-Array Logical Memory Combiner

This block builds one or more logical memories out of a small pool of equal physical arrays. With the default parameters there are four arrays of 1024 words by 8 bits. Each array gets a static configuration: an enable, the logical port it serves, an effective data width of 1, 2, 4 or 8 bits, a stacking index and a role. The width is set by trading data bits for address bits inside the array. When the role is width-stacking, every member of a port sees the same address and contributes its own slice of a wider data word, so four x8 members form a 1024x32 memory. When the role is depth-stacking, every member serves the same low data bits, and the highest logical address bits pick the one member that is read or written, so three x1 members form a 24576x1 memory. Arrays left over can form further logical memories on other ports at the same time, for example a 2048x4 memory next to the 24576x1 one.

Each logical port has its own request interface: address, write data and a write flag, qualified by a valid. The block has no back-pressure. There is no ready signal, and a valid request is taken on every cycle it is presented. A read returns its data exactly one cycle later, flagged by the port's response valid. That response cannot be stalled and must be captured in the cycle it appears. Writes produce no response. A configuration in which two arrays of one port claim the same place is flagged on a combinational error output. The number of logical memories is bounded by the smaller of the array count and the port count.

Top module: `lmem_combiner`

## Requirements
- R1: While reset is held and after it is released, every rsp_valid bit is 0 and every rsp_rdata lane is 0 until a read is issued.
- R2: A read request (req_valid=1, req_we=0) on port p sets rsp_valid[p] in the next cycle and in no other cycle. Writes and idle cycles give rsp_valid[p]=0 in the next cycle. Requests are accepted every cycle.
- R3: Width code k in an array's 2-bit cfg_wcode field gives an effective width of 2^k bits (0=x1, 1=x2, 2=x4, 3=x8) and a depth of 8192/2^k words. The low 3-k local address bits pick a lane within an 8-bit word.
- R4: With cfg_depth bit 0 (width role), an array with stacking index s serves logical addresses 0 to 8192/2^k-1 of its port on data bits [s*2^k +: 2^k].
- R5: With cfg_depth bit 1 (depth role), an array with stacking index s serves port data bits [2^k-1:0] for logical addresses s*D to (s+1)*D-1, where D=8192/2^k. The address bits just above the local range carry the index, and only that array is written or read.
- R6: A logical address that no enabled array of the port serves reads as zero, and a write to it changes no stored data.
- R7: A write changes only the lane it addresses. Other lanes of the same physical word and other arrays keep their contents.
- R8: Ports operate independently and concurrently. Traffic on one logical memory never alters another.
- R9: An array with its cfg_en bit at 0 neither stores writes nor drives read data. Its data bits read as zero.
- R10: cfg_err is 1 exactly when two enabled arrays share a port and either have the same stacking index, differ in role, or differ in width code.
- R11: Read data bits that no selected array drives are 0, and rsp_rdata of a port is 0 whenever its rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | N_ARR | Per-array enable |
| cfg_depth | input | N_ARR | Per-array role: 0 width-stacked, 1 depth-stacked |
| cfg_port | input | N_ARR*PI_W | Per-array logical port index, array i at [i*PI_W +: PI_W] |
| cfg_wcode | input | N_ARR*WC_W | Per-array width code k (width 2^k) |
| cfg_idx | input | N_ARR*SEL_W | Per-array stacking index |
| cfg_err | output | 1 | Conflicting configuration detected |
| req_valid | input | N_PORT | Request valid per port |
| req_we | input | N_PORT | Request is a write |
| req_addr | input | N_PORT*PA_W | Logical word address per port |
| req_wdata | input | N_PORT*PD_W | Write data per port |
| rsp_valid | output | N_PORT | Read data valid, one cycle after a read |
| rsp_rdata | output | N_PORT*PD_W | Read data per port |

## Verification
On every cycle the embedded properties check the response timing of each port, that an idle response lane is zero, that at most one depth-stacked member of a port answers a read, and that a write leaves the unaddressed lanes of its word untouched. The data mapping itself can only be shown by the bench's scenarios. These cover which array and lane hold each logical bit, zero reads and ignored writes outside the populated range, disabled arrays, ports running side by side, and the cases that raise the error flag. The bench compares against a behavioural model of each logical memory.

// File: rtl/lmem_pkg.sv
package lmem_pkg;

  typedef enum logic {
    ROLE_WIDTH = 1'b0,
    ROLE_DEPTH = 1'b1
  } role_e;

  // Number of local address bits used as lane select for a width code.
  function automatic int unsigned lane_sel_bits(int unsigned lane_w, int unsigned wcode);
    return (wcode > lane_w) ? 0 : lane_w - wcode;
  endfunction

endpackage

// File: rtl/lmem_array.sv
module lmem_array
  import lmem_pkg::*;
#(
  parameter int unsigned ARR_DEPTH = 1024,
  parameter int unsigned ARR_W     = 8,
  parameter int unsigned N_ARR     = 4,
  parameter int unsigned PA_W      = 15,
  parameter int unsigned PD_W      = 32,
  localparam int unsigned ROW_W    = $clog2(ARR_DEPTH),
  localparam int unsigned LANE_W   = $clog2(ARR_W),
  localparam int unsigned SEL_W    = $clog2(N_ARR),
  localparam int unsigned WC_W     = $clog2(LANE_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  role_e            cfg_role,
  input  logic [WC_W-1:0]  cfg_wcode,
  input  logic [SEL_W-1:0] cfg_idx,
  input  logic             bus_valid,
  input  logic             bus_we,
  input  logic [PA_W-1:0]  bus_addr,
  input  logic [PD_W-1:0]  bus_wdata,
  output logic             hit_q,
  output logic [PD_W-1:0]  rd_out
);

  logic [ARR_W-1:0] mem [ARR_DEPTH];
  logic [ARR_W-1:0] rd_word_q;
  logic [LANE_W-1:0] off_q;

  logic [31:0] a32, hi, lane, emask;
  int unsigned lb, ew, off, pos;
  logic [ROW_W-1:0] row;
  logic hit;
  logic [PD_W-1:0] src, lane_val;
  logic [ARR_W-1:0] colmask, wbits;

  // Address split: row | lane | owner bits, driven by the width code.
  always_comb begin
    lb      = lane_sel_bits(LANE_W, 32'(cfg_wcode));
    ew      = 32'd1 << (LANE_W - lb);
    a32     = 32'(bus_addr);
    row     = ROW_W'(a32 >> lb);
    lane    = a32 & ((32'd1 << lb) - 32'd1);
    off     = lane * ew;
    hi      = a32 >> (ROW_W + lb);
    hit     = cfg_en && ((cfg_role == ROLE_DEPTH) ? (hi == 32'(cfg_idx)) : (hi == 32'd0));
    emask   = (ew >= 32) ? '1 : ((32'd1 << ew) - 32'd1);
    pos     = (cfg_role == ROLE_DEPTH) ? 0 : 32'(cfg_idx) * ew;
    src     = bus_wdata >> pos;
    colmask = ARR_W'(emask << off);
    wbits   = ARR_W'((32'(src) & emask) << off);
  end

  // Column-masked write and registered read of the addressed word.
  always_ff @(posedge clk) begin
    if (bus_valid && bus_we && hit) begin
      mem[row] <= (mem[row] & ~colmask) | wbits;
    end
    rd_word_q <= mem[row];
    off_q     <= LANE_W'(off);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= bus_valid && !bus_we && hit;
  end

  always_comb begin
    lane_val = PD_W'((32'(rd_word_q) >> off_q) & emask);
    rd_out   = hit_q ? (lane_val << pos) : '0;
  end

  // R7
  lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && hit) |=>
      (((mem[$past(row)] ^ $past(mem[row])) & ~$past(colmask)) == '0));

endmodule

// File: rtl/lmem_cfgcheck.sv
module lmem_cfgcheck #(
  parameter int unsigned N_ARR = 4,
  parameter int unsigned PI_W  = 2,
  parameter int unsigned WC_W  = 2,
  parameter int unsigned SEL_W = 2
) (
  input  logic [N_ARR-1:0]       cfg_en,
  input  logic [N_ARR-1:0]       cfg_depth,
  input  logic [N_ARR*PI_W-1:0]  cfg_port,
  input  logic [N_ARR*WC_W-1:0]  cfg_wcode,
  input  logic [N_ARR*SEL_W-1:0] cfg_idx,
  output logic                   cfg_err
);

  // Pairwise scan: same port must mean same role, same width, distinct index.
  always_comb begin
    cfg_err = 1'b0;
    for (int i = 0; i < N_ARR; i++) begin
      for (int j = i + 1; j < N_ARR; j++) begin
        if (cfg_en[i] && cfg_en[j] &&
            cfg_port[i*PI_W +: PI_W] == cfg_port[j*PI_W +: PI_W]) begin
          if (cfg_depth[i] != cfg_depth[j] ||
              cfg_wcode[i*WC_W +: WC_W] != cfg_wcode[j*WC_W +: WC_W] ||
              cfg_idx[i*SEL_W +: SEL_W] == cfg_idx[j*SEL_W +: SEL_W]) begin
            cfg_err = 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/lmem_rdmerge.sv
module lmem_rdmerge #(
  parameter int unsigned N_ARR  = 4,
  parameter int unsigned N_PORT = 4,
  parameter int unsigned PD_W   = 32,
  parameter int unsigned PI_W   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_ARR-1:0]       arr_en,
  input  logic [N_ARR-1:0]       arr_depth,
  input  logic [N_ARR*PI_W-1:0]  arr_port,
  input  logic [N_ARR-1:0]       arr_hit,
  input  logic [N_ARR*PD_W-1:0]  arr_rd,
  input  logic                   cfg_err,
  input  logic [N_PORT-1:0]      req_valid,
  input  logic [N_PORT-1:0]      req_we,
  output logic [N_PORT-1:0]      rsp_valid,
  output logic [N_PORT*PD_W-1:0] rsp_rdata
);

  logic [N_ARR-1:0] dhit [N_PORT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= '0;
    else        rsp_valid <= req_valid & ~req_we;
  end

  // Unselected arrays drive zero, so a per-port OR is the read mux.
  always_comb begin
    rsp_rdata = '0;
    for (int p = 0; p < N_PORT; p++) begin
      dhit[p] = '0;
      for (int i = 0; i < N_ARR; i++) begin
        if (arr_en[i] && 32'(arr_port[i*PI_W +: PI_W]) == p) begin
          rsp_rdata[p*PD_W +: PD_W] = rsp_rdata[p*PD_W +: PD_W] | arr_rd[i*PD_W +: PD_W];
          dhit[p][i] = arr_hit[i] & arr_depth[i];
        end
      end
    end
  end

  for (genvar p = 0; p < N_PORT; p++) begin : g_chk
    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && !req_we[p]) |=> rsp_valid[p]);
    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid[p] && !req_we[p]) |=> !rsp_valid[p]);
    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid[p] |-> (rsp_rdata[p*PD_W +: PD_W] == '0));
    // R5
    depth_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_err |-> $onehot0(dhit[p]));
  end

endmodule

// File: rtl/lmem_combiner.sv
module lmem_combiner
  import lmem_pkg::*;
#(
  parameter int unsigned N_ARR     = 4,
  parameter int unsigned ARR_DEPTH = 1024,
  parameter int unsigned ARR_W     = 8,
  parameter int unsigned N_PORT    = 4,
  localparam int unsigned ROW_W    = $clog2(ARR_DEPTH),
  localparam int unsigned LANE_W   = $clog2(ARR_W),
  localparam int unsigned SEL_W    = $clog2(N_ARR),
  localparam int unsigned WC_W     = $clog2(LANE_W + 1),
  localparam int unsigned PI_W     = (N_PORT > 1) ? $clog2(N_PORT) : 1,
  localparam int unsigned PA_W     = ROW_W + LANE_W + SEL_W,
  localparam int unsigned PD_W     = N_ARR * ARR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_ARR-1:0]       cfg_en,
  input  logic [N_ARR-1:0]       cfg_depth,
  input  logic [N_ARR*PI_W-1:0]  cfg_port,
  input  logic [N_ARR*WC_W-1:0]  cfg_wcode,
  input  logic [N_ARR*SEL_W-1:0] cfg_idx,
  output logic                   cfg_err,
  input  logic [N_PORT-1:0]      req_valid,
  input  logic [N_PORT-1:0]      req_we,
  input  logic [N_PORT*PA_W-1:0] req_addr,
  input  logic [N_PORT*PD_W-1:0] req_wdata,
  output logic [N_PORT-1:0]      rsp_valid,
  output logic [N_PORT*PD_W-1:0] rsp_rdata
);

  logic [N_ARR-1:0]      a_hit;
  logic [N_ARR*PD_W-1:0] a_rd;

  for (genvar i = 0; i < N_ARR; i++) begin : g_arr
    logic [PI_W-1:0] pi;
    logic            b_valid, b_we;
    logic [PA_W-1:0] b_addr;
    logic [PD_W-1:0] b_wdata;

    // Address mapping: each array listens to the bus of its assigned port.
    always_comb begin
      pi      = cfg_port[i*PI_W +: PI_W];
      b_valid = req_valid[pi];
      b_we    = req_we[pi];
      b_addr  = req_addr[pi*PA_W +: PA_W];
      b_wdata = req_wdata[pi*PD_W +: PD_W];
    end

    lmem_array #(
      .ARR_DEPTH(ARR_DEPTH), .ARR_W(ARR_W), .N_ARR(N_ARR), .PA_W(PA_W), .PD_W(PD_W)
    ) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_en   (cfg_en[i]),
      .cfg_role (role_e'(cfg_depth[i])),
      .cfg_wcode(cfg_wcode[i*WC_W +: WC_W]),
      .cfg_idx  (cfg_idx[i*SEL_W +: SEL_W]),
      .bus_valid(b_valid),
      .bus_we   (b_we),
      .bus_addr (b_addr),
      .bus_wdata(b_wdata),
      .hit_q    (a_hit[i]),
      .rd_out   (a_rd[i*PD_W +: PD_W])
    );
  end

  lmem_cfgcheck #(
    .N_ARR(N_ARR), .PI_W(PI_W), .WC_W(WC_W), .SEL_W(SEL_W)
  ) u_chk (
    .cfg_en   (cfg_en),
    .cfg_depth(cfg_depth),
    .cfg_port (cfg_port),
    .cfg_wcode(cfg_wcode),
    .cfg_idx  (cfg_idx),
    .cfg_err  (cfg_err)
  );

  lmem_rdmerge #(
    .N_ARR(N_ARR), .N_PORT(N_PORT), .PD_W(PD_W), .PI_W(PI_W)
  ) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .arr_en   (cfg_en),
    .arr_depth(cfg_depth),
    .arr_port (cfg_port),
    .arr_hit  (a_hit),
    .arr_rd   (a_rd),
    .cfg_err  (cfg_err),
    .req_valid(req_valid),
    .req_we   (req_we),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

endmodule

// File: tb/lmem_combiner_bench.sv
`timescale 1ns/1ps
module lmem_combiner_bench;

  localparam int NA = 4, NP = 4, PA = 15, PD = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic b_en [NA];
  logic b_dep [NA];
  logic [1:0] b_port [NA];
  logic [1:0] b_wc [NA];
  logic [1:0] b_idx [NA];

  logic [NA-1:0] cfg_en, cfg_depth;
  logic [NA*2-1:0] cfg_port, cfg_wcode, cfg_idx;
  logic cfg_err;
  logic [NP-1:0] req_valid, req_we, rsp_valid;
  logic [PA-1:0] d_addr [NP];
  logic [PD-1:0] d_wdata [NP];
  logic [NP*PA-1:0] req_addr;
  logic [NP*PD-1:0] req_wdata, rsp_rdata;

  always_comb begin
    for (int i = 0; i < NA; i++) begin
      cfg_en[i] = b_en[i];
      cfg_depth[i] = b_dep[i];
      cfg_port[i*2 +: 2] = b_port[i];
      cfg_wcode[i*2 +: 2] = b_wc[i];
      cfg_idx[i*2 +: 2] = b_idx[i];
    end
    for (int p = 0; p < NP; p++) begin
      req_addr[p*PA +: PA] = d_addr[p];
      req_wdata[p*PD +: PD] = d_wdata[p];
    end
  end

  lmem_combiner u_lmem_combiner (
    .clk(clk), .rst_n(rst_n),
    .cfg_en(cfg_en), .cfg_depth(cfg_depth), .cfg_port(cfg_port),
    .cfg_wcode(cfg_wcode), .cfg_idx(cfg_idx), .cfg_err(cfg_err),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string tag = "R1";
  logic [31:0] mdl [int];

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", t, act, exp, $time);
    end
  endtask

  // Behavioural view: which bits of logical word a on port p are populated.
  function automatic logic [31:0] pmask(int p, int a);
    logic [31:0] m;
    m = 0;
    for (int i = 0; i < NA; i++) begin
      if (b_en[i] && int'(b_port[i]) == p) begin
        int w; int d; logic [31:0] lm;
        w = 1 << b_wc[i];
        d = 8192 / w;
        lm = (32'd1 << w) - 1;
        if (b_dep[i]) begin
          if (a / d == int'(b_idx[i])) m |= lm;
        end else if (a < d) begin
          m |= lm << (int'(b_idx[i]) * w);
        end
      end
    end
    return m;
  endfunction

  function automatic logic model_err();
    logic e;
    e = 1'b0;
    for (int i = 0; i < NA; i++)
      for (int j = 0; j < NA; j++)
        if (i != j && b_en[i] && b_en[j] && b_port[i] == b_port[j] &&
            (b_dep[i] != b_dep[j] || b_wc[i] != b_wc[j] || b_idx[i] == b_idx[j]))
          e = 1'b1;
    return e;
  endfunction

  task automatic tick();
    logic [NP-1:0] ev;
    logic [31:0] ed [NP];
    bit care [NP];
    logic eerr;
    for (int p = 0; p < NP; p++) begin
      int a; int key; logic [31:0] m;
      a = int'(d_addr[p]);
      key = p * 65536 + a;
      m = pmask(p, a);
      ev[p] = 1'b0; ed[p] = 0; care[p] = 1'b1;
      if (req_valid[p]) begin
        if (req_we[p]) begin
          if (m != 0) mdl[key] = d_wdata[p] & m;
        end else begin
          ev[p] = 1'b1;
          if (m != 0) begin
            if (mdl.exists(key)) ed[p] = mdl[key];
            else care[p] = 1'b0;
          end
        end
      end
    end
    eerr = model_err();
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      check({tag, " R2 valid"}, 32'(rsp_valid[p]), 32'(ev[p]));
      if (care[p]) check({tag, " R11 data"}, rsp_rdata[p*PD +: PD], ed[p]);
    end
    check("R10 err", 32'(cfg_err), 32'(eerr));
  endtask

  task automatic idle();
    req_valid = '0;
    req_we = '0;
  endtask

  task automatic put(int p, bit we, int a, logic [31:0] d);
    req_valid[p] = 1'b1;
    req_we[p] = we;
    d_addr[p] = PA'(a);
    d_wdata[p] = d;
  endtask

  task automatic setarr(int i, logic en, int port, int wc, int idx, logic dep);
    b_en[i] = en; b_port[i] = 2'(port); b_wc[i] = 2'(wc);
    b_idx[i] = 2'(idx); b_dep[i] = dep;
  endtask

  task automatic newcfg();
    idle();
    tick();
    mdl.delete();
  endtask

  task automatic rand_ops(int n, int lim [NP]);
    for (int k = 0; k < n; k++) begin
      idle();
      for (int p = 0; p < NP; p++) begin
        if (lim[p] > 0 && $urandom_range(3, 0) != 0)
          put(p, $urandom_range(1, 0) == 1, $urandom_range(lim[p], 0), $urandom);
      end
      tick();
    end
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NA; i++) setarr(i, 1'b0, 0, 3, 0, 1'b0);
    idle();
    for (int p = 0; p < NP; p++) begin d_addr[p] = '0; d_wdata[p] = '0; end
    // R1: reset state
    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      check("R1 reset valid", 32'(rsp_valid[p]), 0);
      check("R1 reset data", rsp_rdata[p*PD +: PD], 0);
    end
    rst_n = 1'b1;
    tag = "R1";
    tick(); tick();

    // R4/R3: four x8 width-stacked arrays -> 1024x32 on port 0
    for (int i = 0; i < NA; i++) setarr(i, 1'b1, 0, 3, i, 1'b0);
    newcfg();
    tag = "R4";
    put(0, 1, 0, 32'h11223344); tick();
    put(0, 1, 1023, 32'hA5C3_0F96); tick();
    put(0, 1, 512, 32'hDEADBEEF); tick();
    tag = "R6";
    put(0, 1, 1024, 32'hFFFF_FFFF); tick();
    put(0, 0, 1024, 0); tick();
    put(0, 0, 0, 0); tick();
    tag = "R4";
    put(0, 0, 1023, 0); tick();
    put(0, 0, 512, 0); tick();
    idle(); tick();
    rand_ops(250, '{1100, 0, 0, 0});

    // R9: array 3 disabled, top byte must read zero
    setarr(3, 1'b0, 0, 3, 3, 1'b0);
    newcfg();
    tag = "R9";
    put(0, 1, 5, 32'hCAFEF00D); tick();
    put(0, 0, 5, 0); tick();
    idle(); tick();
    rand_ops(60, '{1100, 0, 0, 0});

    // R5/R8: 24576x1 depth-stacked on port 1, 2048x4 on port 2
    setarr(0, 1'b1, 1, 0, 0, 1'b1);
    setarr(1, 1'b1, 1, 0, 1, 1'b1);
    setarr(2, 1'b1, 1, 0, 2, 1'b1);
    setarr(3, 1'b1, 2, 2, 0, 1'b0);
    newcfg();
    tag = "R5";
    begin
      int pts [12] = '{0, 1, 7, 8, 8191, 8192, 8199, 16383, 16384, 24575, 24576, 32767};
      foreach (pts[k]) begin
        idle(); put(1, 1, pts[k], 32'(k[0])); put(2, 1, k * 100, 32'(k + 3)); tick();
      end
      tag = "R8";
      foreach (pts[k]) begin
        idle(); put(1, 0, pts[k], 0); put(2, 0, k * 100, 0); put(0, 0, pts[k] & 2047, 0); tick();
      end
    end
    tag = "R6";
    idle(); put(2, 1, 2048, 32'hF); tick();
    idle(); put(2, 0, 2048, 0); put(2, 0, 0, 0); tick();
    idle(); put(2, 0, 0, 0); tick();
    tag = "R8";
    rand_ops(400, '{0, 32767, 2500, 0});

    // R7/R3: 4096x4 from two x2 arrays on port 0, depth x8 idx 1 and 3 on port 3
    setarr(0, 1'b1, 0, 1, 0, 1'b0);
    setarr(1, 1'b1, 0, 1, 1, 1'b0);
    setarr(2, 1'b1, 3, 3, 1, 1'b1);
    setarr(3, 1'b1, 3, 3, 3, 1'b1);
    newcfg();
    tag = "R7";
    for (int a = 0; a < 8; a++) begin idle(); put(0, 1, a, 32'(a * 5)); tick(); end
    put(0, 1, 2, 32'h9); tick();
    for (int a = 0; a < 8; a++) begin idle(); put(0, 0, a, 0); tick(); end
    tag = "R5";
    idle(); put(3, 1, 500, 32'h77); tick();
    idle(); put(3, 1, 1500, 32'h5A); tick();
    idle(); put(3, 1, 3100, 32'hC4); tick();
    idle(); put(3, 0, 500, 0); tick();
    idle(); put(3, 0, 1500, 0); tick();
    idle(); put(3, 0, 3100, 0); tick();
    tag = "R3";
    rand_ops(400, '{4200, 0, 0, 4200});

    // R10: conflict cases and legal neighbours
    tag = "R10";
    setarr(0, 1'b1, 0, 3, 0, 1'b0);
    setarr(1, 1'b1, 0, 3, 0, 1'b0);
    setarr(2, 1'b0, 2, 3, 0, 1'b0);
    setarr(3, 1'b0, 3, 3, 0, 1'b0);
    newcfg(); tick();
    setarr(1, 1'b1, 0, 3, 1, 1'b1);
    newcfg(); tick();
    setarr(1, 1'b1, 0, 2, 1, 1'b0);
    newcfg(); tick();
    setarr(1, 1'b1, 1, 3, 0, 1'b0);
    newcfg(); tick();
    setarr(2, 1'b0, 0, 3, 0, 1'b0);
    newcfg(); tick();
    setarr(2, 1'b1, 0, 3, 0, 1'b0);
    newcfg(); tick();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule